// File: doc/BRIEF.md
# Parallel EPROM Read Controller

This block sits between an on-chip host and an asynchronous, read-only parallel memory of 64K words by 16 bits. The memory has two active-low controls: one selects the device, the other gates its data outputs. The host presents a 16-bit word address with a ready/valid handshake. The controller puts the address on the memory bus and pulls the select line low. It pulls the output gate low a fixed number of cycles later, so the gate never lengthens the access. Once every access time has run out, it captures the data bus. It returns the word with a single-cycle valid pulse and raises both controls on the same edge.

All wait counts come from nanosecond parameters and a clock period parameter. Each is rounded up to whole cycles, with a floor of one. After every access the controller holds off the next request until the memory's outputs have stopped driving the bus. A standby input keeps the select line high and refuses new requests, so the memory stays in its low-power state.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the controller returns to idle after that edge: `mem_ce_n`=1, `mem_oe_n`=1, `mem_addr`=0, `rsp_valid`=0.
- R2: `req_ready` is high only while the controller is idle and `standby` is low. A request is taken on an edge where `req_valid` and `req_ready` are both high. After that edge `mem_addr` equals the request address and `mem_ce_n` is 0.
- R3: `mem_oe_n` goes low OE_LAG edges after `mem_ce_n` went low, where OE_LAG = ceil((T_ACC_NS - T_OE_NS)/CLK_PERIOD_NS), minimum 1 (8 at defaults). `mem_oe_n` is never low while `mem_ce_n` is high.
- R4: `mem_addr` does not change while `mem_ce_n` is low.
- R5: The data bus is captured SAMPLE edges after `mem_ce_n` went low. SAMPLE is the largest of ceil(T_ACC_NS/P), ceil(T_CE_NS/P) and OE_LAG + ceil(T_OE_NS/P), each at least 1 (12 at defaults). At that edge `rsp_valid` rises for exactly one cycle carrying the captured word, and both `mem_ce_n` and `mem_oe_n` return to 1.
- R6: After the release edge, `req_ready` stays low for DF = ceil(T_DF_NS/P) cycles (4 at defaults). The output gate is therefore never pulled low again within the float time.
- R7: While `standby` is high, `req_ready` is low and an idle controller keeps `mem_ce_n` at 1 even with `req_valid` high. An access already in flight completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Hold memory deselected, refuse requests |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 16 | Word address of the request |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_data | output | 16 | Read word |
| mem_addr | output | 16 | Address to memory |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_data | input | 16 | Data bus from memory |

## Verification
The bench models the memory's timing in nanoseconds. The bus shows a corrupted word until all three access windows have closed, so a controller that captured even one cycle early would return a wrong word. Requests held valid back to back check the float gap: a design that skipped it would lower `req_ready` too briefly and let the next select start early. Standby is raised both in idle with a pending request and in the middle of an access. A design that let standby abort an access, or take a request during standby, would produce an extra or a missing response. A reset in the middle of an access must drop both controls and the address at once.

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ACC_NS      = 90,
  parameter int T_CE_NS       = 90,
  parameter int T_OE_NS       = 30,
  parameter int T_DF_NS       = 30,
  parameter int AW            = 16,
  parameter int DW            = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          standby,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int ACC_CYC = to_cyc(T_ACC_NS);
  localparam int CE_CYC  = to_cyc(T_CE_NS);
  localparam int OE_CYC  = to_cyc(T_OE_NS);
  localparam int DF_CYC  = to_cyc(T_DF_NS);
  localparam int OE_LAG  = to_cyc(T_ACC_NS - T_OE_NS);
  localparam int S_A     = (ACC_CYC > CE_CYC) ? ACC_CYC : CE_CYC;
  localparam int SAMPLE  = (S_A > OE_LAG + OE_CYC) ? S_A : OE_LAG + OE_CYC;
  localparam int CMAX    = (SAMPLE > DF_CYC) ? SAMPLE : DF_CYC;
  localparam int CW      = $clog2(CMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_FLT} state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  assign req_ready = (state == S_IDLE) && !standby;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid && req_ready) begin
            mem_addr <= req_addr;
            mem_ce_n <= 1'b0;
            cnt      <= '0;
            state    <= S_ACC;
          end
        end
        S_ACC: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(OE_LAG - 1)) mem_oe_n <= 1'b0;
          if (cnt == CW'(SAMPLE - 1)) begin
            rsp_data  <= mem_data;
            rsp_valid <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            cnt       <= '0;
            state     <= S_FLT;
          end
        end
        S_FLT: begin
          if (cnt == CW'(DF_CYC - 1)) state <= S_IDLE;
          else                        cnt   <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

module eprom_rd_ctrl_chk #(
  parameter int DF_CYC = 4,
  parameter int AW     = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          standby,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n
);

  int gap;

  always_ff @(posedge clk) begin
    if (rst)            gap <= DF_CYC;
    else if (!mem_oe_n) gap <= 0;
    else if (gap < DF_CYC) gap <= gap + 1;
  end

  p_oe_needs_ce_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_ce_n);

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_release_on_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (mem_ce_n && mem_oe_n));

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_float_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> (gap >= DF_CYC));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_oe_n && !standby));

  p_standby_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (standby && mem_ce_n && !rsp_valid) |=> mem_ce_n);

endmodule

bind eprom_rd_ctrl eprom_rd_ctrl_chk #(.DF_CYC(DF_CYC), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .standby(standby), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n)
);

// File: tb/test_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module test_eprom_rd_ctrl;

  localparam real TP = 8.0;
  localparam int  P_NS = 8, ACC_NS = 90, CE_NS = 90, OE_NS = 30, DF_NS = 30;

  function automatic int up(int ns);
    int c;
    c = (ns + P_NS - 1) / P_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int LAG  = up(ACC_NS - OE_NS);
  localparam int SMP  = (up(ACC_NS) > LAG + up(OE_NS)) ? up(ACC_NS) : LAG + up(OE_NS);
  localparam int FLT  = up(DF_NS);

  logic clk = 0, rst = 1, standby = 0, req_valid = 0;
  logic [15:0] req_addr = 0, mem_data;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n;
  logic [15:0] rsp_data, mem_addr;

  always #(TP/2) clk = ~clk;

  eprom_rd_ctrl i_eprom_rd_ctrl (
    .clk(clk), .rst(rst), .standby(standby), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_data(mem_data)
  );

  function automatic logic [15:0] pat(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hC3A5;
  endfunction

  // memory timing model in nanoseconds
  realtime t_ce = -1000, t_oe = -1000, t_ad = -1000;
  always @(negedge mem_ce_n) t_ce = $realtime;
  always @(negedge mem_oe_n) t_oe = $realtime;
  always @(mem_addr) t_ad = $realtime;
  initial begin
    mem_data = 16'h0000;
    #0.5;
    forever begin
      if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 &&
          $realtime - t_ce >= CE_NS && $realtime - t_oe >= OE_NS &&
          $realtime - t_ad >= ACC_NS)
        mem_data = pat(mem_addr);
      else
        mem_data = ~pat(mem_addr);
      #1;
    end
  end

  // cycle reference model
  int ph = 0, k = 0, acc_cnt = 0;
  logic e_ce = 1, e_oe = 1, e_rv = 0;
  logic [15:0] e_ad = 0, e_rd = 0;
  bit started = 0;

  always @(posedge clk) begin
    started = 1;
    e_rv = 0;
    if (rst) begin
      ph = 0; e_ce = 1; e_oe = 1; e_ad = 0;
    end else if (ph == 0) begin
      if (req_valid && !standby) begin
        e_ad = req_addr; e_ce = 0; ph = 1; k = 0; acc_cnt++;
      end
    end else if (ph == 1) begin
      k++;
      if (k == LAG) e_oe = 0;
      if (k == SMP) begin
        e_rv = 1; e_rd = pat(e_ad); e_ce = 1; e_oe = 1; ph = 2; k = 0;
      end
    end else begin
      k++;
      if (k == FLT) ph = 0;
    end
  end

  int nvec = 0, nbad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (started && !done) begin
      chk("R3 ce_n", mem_ce_n, e_ce);
      chk("R3 oe_n", mem_oe_n, e_oe);
      chk("R4 mem_addr", mem_addr, e_ad);
      chk("R5 rsp_valid", rsp_valid, e_rv);
      if (e_rv) chk("R5 rsp_data", rsp_data, e_rd);
      chk(standby ? "R7 ready" : (ph == 2 ? "R6 ready" : "R2 ready"),
          req_ready, (ph == 0) && !standby);
    end
    if (cyc > 150000 && !done) begin
      done = 1; nbad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic rd(logic [15:0] a, bit keep);
    int n0;
    @(negedge clk); #1;
    req_valid = 1; req_addr = a;
    n0 = acc_cnt;
    while (acc_cnt == n0) @(negedge clk);
    if (!keep) begin #1; req_valid = 0; end
  endtask

  task automatic settle();
    repeat (SMP + FLT + 4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ce_n", mem_ce_n, 1); chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 addr", mem_addr, 0); chk("R1 rsp_valid", rsp_valid, 0);
    #1 rst = 0;
    rd(16'h1234, 0); settle();
    rd(16'hFFFF, 0); settle();
    rd(16'h0000, 0); settle();
    // back-to-back with valid held: float gap, R6
    rd(16'hA5A5, 1); rd(16'h5A5A, 1); rd(16'h0F0F, 0); settle();
    // standby in idle with pending request: R7
    @(negedge clk); #1; standby = 1; req_valid = 1; req_addr = 16'h7777;
    repeat (20) @(negedge clk);
    chk("R7 ce held high", mem_ce_n, 1);
    #1 standby = 0;
    @(negedge clk); #1 req_valid = 0;
    settle();
    // standby raised mid-access: access completes
    rd(16'h4321, 0);
    repeat (3) @(negedge clk);
    #1 standby = 1;
    settle();
    #1 standby = 0;
    // reset mid-access: R1
    rd(16'hBEEF, 0);
    repeat (5) @(negedge clk);
    #1 rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 ce_n mid", mem_ce_n, 1); chk("R1 oe_n mid", mem_oe_n, 1);
    chk("R1 addr mid", mem_addr, 0);
    #1 rst = 0;
    for (int i = 0; i < 20; i++) rd(16'(i * 16'h3C71 + 16'h0101), (i % 3) != 0);
    @(negedge clk); #1 req_valid = 0;
    settle();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule